// File: doc/BRIEF.md
# Transmit and Receive FIFO Pair with Occupancy and Threshold Events

This block stores the outgoing and incoming byte streams of a two-wire serial bus controller. The outgoing side is a 16-entry queue of 10-bit words. Each word is a data byte plus two control bits for the bus sequencer. The incoming side is a 16-entry queue of 8-bit bytes. The register bus pushes outgoing words and pops incoming bytes. The bus sequencer does the reverse.

The block reports both queues to the register bank in a compact form. Each occupancy value is zero-based: it reads as the number of stored entries minus one. Four status flags report the full and empty state of each queue. Three level events feed the interrupt logic: outgoing queue empty, outgoing queue at or below half depth, and incoming queue at or above a programmable fill threshold. A flush input clears the outgoing queue and keeps it empty for as long as it is held.

Each queue is tracked by a three-state level machine with the states LVL_EMPTY, LVL_PARTIAL and LVL_FULL. The transitions are:
- FILL_FIRST: LVL_EMPTY to LVL_PARTIAL, on a push.
- FILL_LAST: LVL_PARTIAL to LVL_FULL, on a push alone when one slot is left.
- DRAIN_LAST: LVL_PARTIAL to LVL_EMPTY, on a pop alone when one entry is left.
- DRAIN_FIRST: LVL_FULL to LVL_PARTIAL, on a pop.
- FLUSH: any state to LVL_EMPTY, when the flush input is high.

Top module: `iic_fifo_pair`

## Requirements
- R1: Each queue holds up to 16 entries and returns them in the order they were pushed. The read data shows the oldest entry without needing a pop. Outgoing entries are 10 bits wide and incoming entries are 8 bits wide.
- R2: Each occupancy output reads as the entry count minus one when the queue holds entries, and reads 0 when the queue is empty.
- R3: A push to a full queue is ignored. A pop from an empty queue is ignored. Neither one changes the stored contents or the read order.
- R4: The status byte has outgoing full at bit 4, incoming full at bit 5, incoming empty at bit 6 and outgoing empty at bit 7. Bits 3 to 0 read 0.
- R5: Holding tx_flush high empties the outgoing queue at the next clock edge. The queue stays empty, and pushes to it are ignored, for as long as tx_flush is held.
- R6: tx_half_evt is high in every cycle in which the outgoing queue holds 8 entries or fewer.
- R7: tx_empty_evt is high in every cycle in which the outgoing queue holds no entries.
- R8: The 4-bit receive threshold register resets to 0 and is loaded by rx_thr_we. rx_thresh_evt is high in every cycle in which the incoming queue holds threshold plus one entries or more.
- R9: Each pop of a non-empty incoming queue removes exactly one entry. A push and a pop in the same cycle leave the count unchanged.
- R10: After reset both queues are empty, both occupancy outputs read 0, the status byte reads 0xC0, tx_empty_evt and tx_half_evt are high, and rx_thresh_evt is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tx_flush | input | 1 | Empties the outgoing queue and holds it empty |
| tx_push | input | 1 | Push tx_wdata into the outgoing queue |
| tx_wdata | input | 10 | Outgoing word: data byte and two control bits |
| tx_pop | input | 1 | Sequencer takes the oldest outgoing word |
| tx_rdata | output | 10 | Oldest outgoing word |
| rx_push | input | 1 | Sequencer pushes a received byte |
| rx_wdata | input | 8 | Received byte |
| rx_pop | input | 1 | Register-bus read of the incoming data port |
| rx_rdata | output | 8 | Oldest incoming byte |
| rx_thr_we | input | 1 | Load the receive threshold register |
| rx_thr_wdata | input | 4 | New zero-based receive threshold |
| rx_thr_q | output | 4 | Current receive threshold |
| tx_occ | output | 4 | Zero-based outgoing occupancy |
| rx_occ | output | 4 | Zero-based incoming occupancy |
| status_flags | output | 8 | Full and empty flags at bits 7 to 4 |
| tx_empty_evt | output | 1 | Outgoing queue empty (level) |
| tx_half_evt | output | 1 | Outgoing queue at or below half depth (level) |
| rx_thresh_evt | output | 1 | Incoming fill at or above threshold plus one (level) |

## Verification
If a level machine disagrees with its counter, the status flags and the occupancy outputs disagree at the ports in the very next cycle. For example, the queue could read as empty while the occupancy reads 15. A pointer that moves on an ignored push or pop shows up as the wrong word on the read data, at the next pop or at the next push into an empty queue. The directed tests fill each queue to its limit, push past it, drain past it and flush while pushing, so each such fault shows up within one sequence of at most 17 operations.

// File: rtl/iic_fifo_pkg.sv
package iic_fifo_pkg;

    typedef enum logic [1:0] {
        LVL_EMPTY   = 2'd0,
        LVL_PARTIAL = 2'd1,
        LVL_FULL    = 2'd2
    } lvl_state_t;

    // Status byte bit positions (decoded by the register bank)
    localparam int SB_TX_FULL  = 4;
    localparam int SB_RX_FULL  = 5;
    localparam int SB_RX_EMPTY = 6;
    localparam int SB_TX_EMPTY = 7;

endpackage

// File: rtl/iic_fifo_lane.sv
module iic_fifo_lane
    import iic_fifo_pkg::*;
#(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    lvl_state_t       state, state_nx;
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic [WIDTH-1:0] mem [DEPTH];
    logic             do_push, do_pop;

    assign do_push = push && (state != LVL_FULL) && !flush;
    assign do_pop  = pop && (state != LVL_EMPTY) && !flush;

    // Next-state logic of the level machine
    always_comb begin
        state_nx = state;
        if (flush) begin
            state_nx = LVL_EMPTY;                              // FLUSH
        end else begin
            unique case (state)
                LVL_EMPTY:   if (do_push) state_nx = LVL_PARTIAL; // FILL_FIRST
                LVL_PARTIAL: begin
                    if (do_push && !do_pop && count == CNT_W'(DEPTH - 1))
                        state_nx = LVL_FULL;                   // FILL_LAST
                    else if (do_pop && !do_push && count == CNT_W'(1))
                        state_nx = LVL_EMPTY;                  // DRAIN_LAST
                end
                LVL_FULL:    if (do_pop) state_nx = LVL_PARTIAL;  // DRAIN_FIRST
                default:     state_nx = LVL_EMPTY;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LVL_EMPTY;
        else        state <= state_nx;
    end

    // Pointers and count
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (do_pop && !do_push) count <= count - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wdata;
    end

    // Outputs
    always_comb begin
        full  = (state == LVL_FULL);
        empty = (state == LVL_EMPTY);
        rdata = mem[rd_ptr];
    end

    // R3: a push into a full queue leaves it full
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CNT_W'(DEPTH)));

    // R3: a pop from an empty queue leaves it empty
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push && !flush) |=> (count == '0));

    // R3: level machine and counter agree
    p_state_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (count == '0)) && (full == (count == CNT_W'(DEPTH))));

    // R5: flush empties the queue at the next edge
    p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (count == '0));

    // R9: a lone pop of a non-empty queue removes one entry
    p_pop_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && !empty) |=> (count == $past(count) - 1'b1));

endmodule

// File: rtl/iic_fifo_pair.sv
module iic_fifo_pair
    import iic_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int TX_W  = 10,
    parameter int RX_W  = 8,
    localparam int OCC_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_flush,
    input  logic             tx_push,
    input  logic [TX_W-1:0]  tx_wdata,
    input  logic             tx_pop,
    output logic [TX_W-1:0]  tx_rdata,
    input  logic             rx_push,
    input  logic [RX_W-1:0]  rx_wdata,
    input  logic             rx_pop,
    output logic [RX_W-1:0]  rx_rdata,
    input  logic             rx_thr_we,
    input  logic [OCC_W-1:0] rx_thr_wdata,
    output logic [OCC_W-1:0] rx_thr_q,
    output logic [OCC_W-1:0] tx_occ,
    output logic [OCC_W-1:0] rx_occ,
    output logic [7:0]       status_flags,
    output logic             tx_empty_evt,
    output logic             tx_half_evt,
    output logic             rx_thresh_evt
);

    logic [CNT_W-1:0] tx_cnt, rx_cnt;
    logic             tx_full, tx_empty, rx_full, rx_empty;

    iic_fifo_lane #(.WIDTH(TX_W), .DEPTH(DEPTH)) u_tx_lane (
        .clk(clk), .rst_n(rst_n), .flush(tx_flush),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    iic_fifo_lane #(.WIDTH(RX_W), .DEPTH(DEPTH)) u_rx_lane (
        .clk(clk), .rst_n(rst_n), .flush(1'b0),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         rx_thr_q <= '0;
        else if (rx_thr_we) rx_thr_q <= rx_thr_wdata;
    end

    function automatic logic [OCC_W-1:0] zero_based(input logic [CNT_W-1:0] c);
        logic [CNT_W-1:0] m;
        m = c - 1'b1;
        return (c == '0) ? '0 : m[OCC_W-1:0];
    endfunction

    always_comb begin
        tx_occ        = zero_based(tx_cnt);
        rx_occ        = zero_based(rx_cnt);
        status_flags  = '0;
        status_flags[SB_TX_FULL]  = tx_full;
        status_flags[SB_RX_FULL]  = rx_full;
        status_flags[SB_RX_EMPTY] = rx_empty;
        status_flags[SB_TX_EMPTY] = tx_empty;
        tx_empty_evt  = tx_empty;
        tx_half_evt   = (tx_cnt <= CNT_W'(DEPTH / 2));
        rx_thresh_evt = (rx_cnt >= ({1'b0, rx_thr_q} + 1'b1));
    end

    // R7 / R6: an empty transmit queue is also at or below half depth
    p_empty_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty_evt |-> tx_half_evt);

    // R8: a full receive queue always meets any threshold
    p_full_thresh_r8: assert property (@(posedge clk) disable iff (!rst_n)
        status_flags[SB_RX_FULL] |-> rx_thresh_evt);

    // R2: empty flag and zero-based occupancy agree
    p_occ_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        status_flags[SB_TX_EMPTY] |-> (tx_occ == '0));

    // R5: while the flush is held the queue stays empty
    p_flush_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_flush && $past(tx_flush)) |-> tx_empty_evt);

endmodule

// File: tb/iic_fifo_pair_test.sv
module iic_fifo_pair_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_flush = 0, tx_push = 0, tx_pop = 0;
    logic [9:0] tx_wdata = '0;
    logic [9:0] tx_rdata;
    logic       rx_push = 0, rx_pop = 0, rx_thr_we = 0;
    logic [7:0] rx_wdata = '0;
    logic [7:0] rx_rdata;
    logic [3:0] rx_thr_wdata = '0;
    logic [3:0] rx_thr_q, tx_occ, rx_occ;
    logic [7:0] status_flags;
    logic       tx_empty_evt, tx_half_evt, rx_thresh_evt;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    iic_fifo_pair uut (
        .clk(clk), .rst_n(rst_n), .tx_flush(tx_flush),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_thr_we(rx_thr_we), .rx_thr_wdata(rx_thr_wdata), .rx_thr_q(rx_thr_q),
        .tx_occ(tx_occ), .rx_occ(rx_occ), .status_flags(status_flags),
        .tx_empty_evt(tx_empty_evt), .tx_half_evt(tx_half_evt),
        .rx_thresh_evt(rx_thresh_evt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One clock edge; inputs were set before it, outputs are settled after it
    task automatic tick();
        @(posedge clk);
        #1;
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0; rx_thr_we = 0;
    endtask

    function automatic logic [9:0] tx_pat(input int i);
        return 10'((i * 37 + 5) & 10'h3FF);
    endfunction

    task automatic t_reset();
        check("R10 tx_occ", tx_occ, 0);
        check("R10 rx_occ", rx_occ, 0);
        check("R10 status", status_flags, 8'hC0);
        check("R10 tx_empty_evt", tx_empty_evt, 1);
        check("R10 tx_half_evt", tx_half_evt, 1);
        check("R10 rx_thresh_evt", rx_thresh_evt, 0);
        check("R8 thr reset", rx_thr_q, 0);
        rx_push = 1; rx_wdata = 8'h5A; tick();
        check("R8 thr0 one entry", rx_thresh_evt, 1);
        check("R4 rx not empty", status_flags[6], 0);
        check("R1 rx head", rx_rdata, 8'h5A);
        rx_pop = 1; tick();
        check("R9 rx drained", status_flags[6], 1);
    endtask

    task automatic t_tx_fill_drain();
        for (int i = 0; i < 16; i++) begin
            tx_push = 1; tx_wdata = tx_pat(i); tick();
            check("R2 tx_occ fill", tx_occ, i);
            if (i == 7) check("R6 half at 8", tx_half_evt, 1);
            if (i == 8) check("R6 half at 9", tx_half_evt, 0);
            if (i == 0) check("R7 not empty", tx_empty_evt, 0);
        end
        check("R4 tx full", status_flags[4], 1);
        check("R4 low nibble", status_flags[3:0], 0);
        tx_push = 1; tx_wdata = 10'h3FF; tick();
        check("R3 push full ignored occ", tx_occ, 15);
        for (int i = 0; i < 16; i++) begin
            check("R1 tx order", tx_rdata, tx_pat(i));
            tx_pop = 1; tick();
        end
        check("R7 tx empty evt", tx_empty_evt, 1);
        check("R4 tx empty flag", status_flags[7], 1);
        check("R2 occ empty", tx_occ, 0);
        tx_pop = 1; tick();
        check("R3 pop empty ignored", status_flags[7], 1);
        tx_push = 1; tx_wdata = 10'h2C3; tick();
        check("R3 pointers intact", tx_rdata, 10'h2C3);
        check("R2 occ one", tx_occ, 0);
        tx_pop = 1; tick();
    endtask

    task automatic t_rx_threshold();
        rx_thr_we = 1; rx_thr_wdata = 4'd3; tick();
        check("R8 thr load", rx_thr_q, 3);
        for (int i = 0; i < 3; i++) begin
            rx_push = 1; rx_wdata = 8'(8'h10 + i); tick();
        end
        check("R8 below thr", rx_thresh_evt, 0);
        rx_push = 1; rx_wdata = 8'h13; tick();
        check("R8 at thr", rx_thresh_evt, 1);
        check("R2 rx_occ 4", rx_occ, 3);
        rx_push = 1; rx_wdata = 8'h14; rx_pop = 1; tick();
        check("R9 push+pop count", rx_occ, 3);
        check("R1 rx order", rx_rdata, 8'h11);
        rx_pop = 1; tick();
        check("R9 pop one", rx_occ, 2);
        check("R8 below again", rx_thresh_evt, 0);
        for (int i = 0; i < 3; i++) begin rx_pop = 1; tick(); end
        check("R9 rx empty", status_flags[6], 1);
        rx_thr_we = 1; rx_thr_wdata = 4'd15; tick();
        for (int i = 0; i < 16; i++) begin
            rx_push = 1; rx_wdata = 8'(i); tick();
            if (i == 14) check("R8 thr15 at 15", rx_thresh_evt, 0);
        end
        check("R8 thr15 at 16", rx_thresh_evt, 1);
        check("R4 rx full", status_flags[5], 1);
        rx_push = 1; rx_wdata = 8'hEE; tick();
        check("R3 rx push full", rx_occ, 15);
        for (int i = 0; i < 16; i++) begin
            check("R1 rx full order", rx_rdata, i);
            rx_pop = 1; tick();
        end
        check("R4 rx empty after drain", status_flags[6], 1);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 5; i++) begin
            tx_push = 1; tx_wdata = tx_pat(i + 20); tick();
        end
        check("R2 pre flush occ", tx_occ, 4);
        tx_flush = 1;
        for (int i = 0; i < 3; i++) begin
            tx_push = 1; tx_wdata = 10'h155; tick();
            check("R5 flush empty", status_flags[7], 1);
            check("R5 flush occ", tx_occ, 0);
        end
        tx_flush = 0;
        tx_push = 1; tx_wdata = 10'h0AA; tick();
        check("R5 after flush head", tx_rdata, 10'h0AA);
        check("R5 after flush not empty", tx_empty_evt, 0);
        tx_pop = 1; tick();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_tx_fill_drain();
        t_rx_threshold();
        t_flush();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule